// File: doc/BRIEF.md
# Multi-Digit Seven-Segment Display Driver with Zero Suppression

This block turns a packed row of BCD nibbles into active-low segment lines, one decoder slice per digit. The slices pass a zero-suppression signal from the most significant digit down to the least significant one. Leading zeros go dark, and the first non-zero digit ends the suppression for every digit below it. The least significant digit always shows, so an all-zero value still reads as a single 0.

Three global controls sit on top of the slices. A blanking input darkens everything. A lamp-test input lights every segment. An intensity generator dims the whole row by forcing blanking for part of every 256-cycle period. Its duty is set by an 8-bit brightness value. The intensity generator is the only clocked logic. The decode path is combinational from the inputs and the generator's counter.

Top module: `segdrv_top`

## Requirements
- R1: Segment lines are active-low (0 lights a segment). Each digit owns 7 bits: digit i uses segN[7i+6:7i] with segment a at bit 0 and g at bit 6, and it reads bcdIn[4i+3:4i]. Digit NUM_DIGITS-1 is the most significant. Codes 0-9 light these segments (lit set as {g..a} hex): 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F. The 6 includes segment a and the 9 includes segment d.
- R2: Codes 10 to 14 light the non-numeric patterns 58, 4C, 62, 69, 78 (same encoding as R1), in that code order. Code 15 lights nothing.
- R3: While blankN is low, every segment of every digit is off, whatever the other inputs are.
- R4: While no blanking is in force and lampTestN is low, every segment of every digit is lit, whatever the BCD value is.
- R5: The most significant digit's suppression input is held active. A digit whose suppression input is active and whose code is 0 is dark, and it drives its zeroBlankN low to the next lower digit. This applies only when lamp test is inactive.
- R6: The least significant digit never suppresses its zero, and zeroBlankN[0] is always 1.
- R7: A digit with a non-zero code, or with its suppression input inactive, drives zeroBlankN high, so zeros below it are displayed. zeroBlankN does not depend on blanking.
- R8: Lamp test overrides zero suppression. All segments are lit and all of zeroBlankN is high.
- R9: An 8-bit counter is 0 during reset and increases by 1 (wrapping) on every clock edge after reset. Blanking is forced in every cycle where the counter is greater than or equal to brightness.
- R10: Brightness 0 keeps the display dark in every cycle. Brightness 255 lights the display in 255 of every 256 cycles, and a brightness of N lights it in N of 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the intensity counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcdIn | input | 4*NUM_DIGITS | Packed BCD codes, most significant digit in the top nibble |
| brightness | input | DIM_W | On-time per 256-cycle period |
| blankN | input | 1 | Global blanking, active low |
| lampTestN | input | 1 | Global lamp test, active low |
| segN | output | 7*NUM_DIGITS | Active-low segment lines, a..g per digit |
| zeroBlankN | output | NUM_DIGITS | Per-digit zero-suppression output, low when that digit was suppressed |

## Verification
The hardest point to reach from the ports is the interaction between the decode checks and the intensity counter. This counter runs freely and cannot be loaded, so any decode sample may fall in a cycle where dimming is forced. The bench keeps its own count of edges since reset, which it derives from R9, and it folds the forced blanking into every expected value. For the duty checks it counts lit cycles over one full 256-cycle window, so the result does not depend on phase. The chain cases are reached with chosen values: all zeros, a zero below a non-zero digit, and lamp test on an all-zero value.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;

  typedef struct packed {
    logic blank;
    logic lamp;
  } drv_strobe_t;

  // lit-segment pattern, bit 0 = a ... bit 6 = g
  function automatic logic [6:0] glyphOf(input logic [3:0] code);
    logic [6:0] lit;
    case (code)
      4'd0:    lit = 7'h3F;
      4'd1:    lit = 7'h06;
      4'd2:    lit = 7'h5B;
      4'd3:    lit = 7'h4F;
      4'd4:    lit = 7'h66;
      4'd5:    lit = 7'h6D;
      4'd6:    lit = 7'h7D;
      4'd7:    lit = 7'h07;
      4'd8:    lit = 7'h7F;
      4'd9:    lit = 7'h6F;
      4'd10:   lit = 7'h58;
      4'd11:   lit = 7'h4C;
      4'd12:   lit = 7'h62;
      4'd13:   lit = 7'h69;
      4'd14:   lit = 7'h78;
      default: lit = 7'h00;
    endcase
    return lit;
  endfunction

endpackage

// File: rtl/segdrv_dim_ctrl.sv
module segdrv_dim_ctrl
  import segdrv_pkg::*;
#(
  parameter int DIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIM_W-1:0] brightness,
  input  logic             blankN,
  input  logic             lampTestN,
  output drv_strobe_t      strb,
  output logic [DIM_W-1:0] dimCnt
);

  logic dimHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dimCnt <= '0;
    else        dimCnt <= dimCnt + 1'b1;
  end

  assign dimHit     = (dimCnt >= brightness);
  assign strb.blank = ~blankN | dimHit;
  assign strb.lamp  = ~lampTestN;

endmodule

// File: rtl/segdrv_digit.sv
module segdrv_digit
  import segdrv_pkg::*;
(
  input  logic [3:0]  code,
  input  logic        rbiN,
  input  drv_strobe_t strb,
  output logic [6:0]  segN,
  output logic        rboN
);

  logic zeroSup;

  assign zeroSup = ~rbiN & (code == 4'd0) & ~strb.lamp;
  assign rboN    = ~zeroSup;

  always_comb begin
    if (strb.blank)     segN = 7'h7F;
    else if (strb.lamp) segN = 7'h00;
    else if (zeroSup)   segN = 7'h7F;
    else                segN = ~glyphOf(code);
  end

endmodule

// File: rtl/segdrv_digit_row.sv
module segdrv_digit_row
  import segdrv_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  localparam int BCD_W = 4 * NUM_DIGITS,
  localparam int SEG_W = 7 * NUM_DIGITS
) (
  input  logic [BCD_W-1:0]      bcdIn,
  input  drv_strobe_t           strb,
  output logic [SEG_W-1:0]      segN,
  output logic [NUM_DIGITS-1:0] zeroBlankN
);

  logic [NUM_DIGITS-1:0] rbiN;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    if (i == 0) begin : g_lsd
      assign rbiN[i] = 1'b1;
    end else if (i == NUM_DIGITS - 1) begin : g_msd
      assign rbiN[i] = 1'b0;
    end else begin : g_mid
      assign rbiN[i] = zeroBlankN[i+1];
    end

    segdrv_digit u_digit (
      .code (bcdIn[4*i +: 4]),
      .rbiN (rbiN[i]),
      .strb (strb),
      .segN (segN[7*i +: 7]),
      .rboN (zeroBlankN[i])
    );
  end

endmodule

// File: rtl/segdrv_top.sv
module segdrv_top
  import segdrv_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int DIM_W      = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [4*NUM_DIGITS-1:0] bcdIn,
  input  logic [DIM_W-1:0]        brightness,
  input  logic                    blankN,
  input  logic                    lampTestN,
  output logic [7*NUM_DIGITS-1:0] segN,
  output logic [NUM_DIGITS-1:0]   zeroBlankN
);

  drv_strobe_t      strb;
  logic [DIM_W-1:0] dimCnt;

  segdrv_dim_ctrl #(.DIM_W(DIM_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .brightness (brightness),
    .blankN     (blankN),
    .lampTestN  (lampTestN),
    .strb       (strb),
    .dimCnt     (dimCnt)
  );

  segdrv_digit_row #(.NUM_DIGITS(NUM_DIGITS)) u_row (
    .bcdIn      (bcdIn),
    .strb       (strb),
    .segN       (segN),
    .zeroBlankN (zeroBlankN)
  );

endmodule

// File: rtl/segdrv_checker.sv
module segdrv_checker
  import segdrv_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int DIM_W      = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [4*NUM_DIGITS-1:0] bcdIn,
  input logic [DIM_W-1:0]        brightness,
  input logic                    blankN,
  input logic                    lampTestN,
  input logic [7*NUM_DIGITS-1:0] segN,
  input logic [NUM_DIGITS-1:0]   zeroBlankN,
  input drv_strobe_t             strb,
  input logic [DIM_W-1:0]        dimCnt
);

  assert_blank_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !blankN |-> (&segN));

  assert_lamp_lit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.blank && !lampTestN) |-> (segN == '0));

  assert_lamp_noripple_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lampTestN |-> (&zeroBlankN));

  assert_lsd_never_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    zeroBlankN[0]);

  assert_msd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lampTestN && bcdIn[4*NUM_DIGITS-1 -: 4] == 4'd0 && NUM_DIGITS > 1)
      |-> !zeroBlankN[NUM_DIGITS-1]);

  assert_counter_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (dimCnt == DIM_W'($past(dimCnt) + 1'b1)));

  assert_dark_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (brightness == '0) |-> (&segN));

endmodule

bind segdrv_top segdrv_checker #(.NUM_DIGITS(NUM_DIGITS), .DIM_W(DIM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bcdIn      (bcdIn),
  .brightness (brightness),
  .blankN     (blankN),
  .lampTestN  (lampTestN),
  .segN       (segN),
  .zeroBlankN (zeroBlankN),
  .strb       (strb),
  .dimCnt     (dimCnt)
);

// File: tb/sim_segdrv_top.sv
module sim_segdrv_top;

  localparam int CLK_PERIOD = 10;
  localparam int ND = 4;

  typedef struct {
    logic [7*ND-1:0] seg;
    logic [ND-1:0]   zb;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4*ND-1:0] bcdIn = '0;
  logic [7:0]      brightness = 8'd255;
  logic            blankN = 1'b1;
  logic            lampTestN = 1'b1;
  logic [7*ND-1:0] segN;
  logic [ND-1:0]   zeroBlankN;

  logic [7:0] mCnt;
  int checks = 0;
  int errors = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // edge count since reset, per R9
  always @(posedge clk) begin
    if (!rst_n) mCnt <= 8'd0;
    else        mCnt <= mCnt + 8'd1;
  end

  segdrv_top #(.NUM_DIGITS(ND), .DIM_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bcdIn(bcdIn), .brightness(brightness),
    .blankN(blankN), .lampTestN(lampTestN), .segN(segN), .zeroBlankN(zeroBlankN)
  );

  function automatic logic [6:0] litOf(input logic [3:0] c);
    case (c)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;  10: return 7'h58; 11: return 7'h4C;
      12: return 7'h62; 13: return 7'h69; 14: return 7'h78; default: return 7'h00;
    endcase
  endfunction

  function automatic exp_t model(input logic [4*ND-1:0] b, input logic lt,
                                 input logic bn, input logic [7:0] br,
                                 input logic [7:0] cnt, input string tag);
    exp_t e;
    logic blank, rbi, sup;
    blank = !bn || (cnt >= br);
    rbi = 1'b0;
    e.tag = tag;
    for (int i = ND - 1; i >= 0; i--) begin
      logic [3:0] c;
      c = b[4*i +: 4];
      if (i == 0) rbi = 1'b1;
      sup = !rbi && (c == 4'd0) && lt;
      e.zb[i] = !sup;
      if (blank)    e.seg[7*i +: 7] = 7'h7F;
      else if (!lt) e.seg[7*i +: 7] = 7'h00;
      else if (sup) e.seg[7*i +: 7] = 7'h7F;
      else          e.seg[7*i +: 7] = ~litOf(c);
      rbi = e.zb[i];
    end
    return e;
  endfunction

  task automatic apply(input logic [4*ND-1:0] b, input logic lt, input logic bn,
                       input logic [7:0] br, input string tag);
    @(negedge clk);
    bcdIn = b; lampTestN = lt; blankN = bn; brightness = br;
    #1;
    q.push_back(model(b, lt, bn, br, mCnt, tag));
  endtask

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (segN !== e.seg) begin
          errors++;
          $display("FAIL %s segN actual=%h expected=%h", e.tag, segN, e.seg);
        end
        checks++;
        if (zeroBlankN !== e.zb) begin
          errors++;
          $display("FAIL %s zeroBlankN actual=%b expected=%b", e.tag, zeroBlankN, e.zb);
        end
      end
    end
  end

  task automatic dutyCheck(input logic [7:0] br, input int expLit, input string tag);
    int lit;
    lit = 0;
    @(negedge clk);
    bcdIn = 16'h8888; lampTestN = 1'b1; blankN = 1'b1; brightness = br;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      #2;
      if (segN[6:0] != 7'h7F) lit++;
    end
    checks++;
    if (lit != expLit) begin
      errors++;
      $display("FAIL %s lit cycles actual=%0d expected=%0d", tag, lit, expLit);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // reset state R9: counter 0, bright 255 -> lit; R6 all-zero shows one 0
    repeat (3) @(negedge clk);
    #2;
    checks++;
    if (segN !== {7'h7F, 7'h7F, 7'h7F, ~7'h3F} || zeroBlankN !== 4'b0001) begin
      errors++;
      $display("FAIL R9 R6 reset actual=%h/%b expected=%h/%b", segN, zeroBlankN,
               {7'h7F, 7'h7F, 7'h7F, ~7'h3F}, 4'b0001);
    end
    @(negedge clk);
    rst_n = 1'b1;

    apply(16'h1234, 1, 1, 8'd255, "R1 digits 1234");
    apply(16'h5678, 1, 1, 8'd255, "R1 digits 5678");
    apply(16'h9966, 1, 1, 8'd255, "R1 tailed 6 and 9");
    apply(16'h1090, 1, 1, 8'd255, "R7 zeros below nonzero");
    apply(16'hABCD, 1, 1, 8'd255, "R2 codes 10-13");
    apply(16'h1EFA, 1, 1, 8'd255, "R2 code 14 and 15");
    apply(16'hF000, 1, 1, 8'd255, "R2 R7 code 15 msd");
    apply(16'h0005, 1, 1, 8'd255, "R5 leading zeros");
    apply(16'h0050, 1, 1, 8'd255, "R5 R7 trailing zero shown");
    apply(16'h0000, 1, 1, 8'd255, "R6 single zero");
    apply(16'h0000, 0, 1, 8'd255, "R8 lamp over suppression");
    apply(16'h1234, 0, 1, 8'd255, "R4 lamp test");
    apply(16'h8888, 0, 0, 8'd255, "R3 blank over lamp");
    apply(16'h0005, 1, 0, 8'd255, "R3 R7 blank keeps ripple");
    for (int k = 0; k < 6; k++)
      apply(16'h2468, 1, 1, 8'd3, "R9 dim window");

    dutyCheck(8'd0,   0,   "R10 brightness 0");
    dutyCheck(8'd255, 255, "R10 brightness 255");
    dutyCheck(8'd100, 100, "R9 R10 brightness 100");

    repeat (3) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule